// File: doc/BRIEF.md
# Cascadable Serial Bitstream ROM

This block is a one-bit-wide read-only store that shifts out a fixed configuration bitstream, one bit per clock. An internal address pointer selects the bit shown on the data output and moves forward on every rising clock edge while the device is enabled. The output is a data bit plus an output-enable flag, so that several devices can share one data line. A device drives that line only while it is selected, out of reset and not yet finished.

When the last stored bit has been shifted out, the device stops driving and pulls its cascade output active. That output feeds the enable input of the next device in the chain, which then carries on with the stream. The clock and the data line are common to every device in the chain. A single pin does two jobs: it resets the pointer and it gates the output. Its active level is chosen by a parameter. The stored bits come either from a parameter vector or from a built-in generator function.

Top module: `serial_cfg_rom`

## Requirements
- R1: While enabled, out of reset and not finished, the device outputs the bit at the current address. Each rising clock edge advances the address by one, so bit k appears in the k-th cycle after reset is released.
- R2: With CONTENT_SEL=0, bit i equals the XOR-reduction of the low 16 bits of (i*40503) XOR SEED. With CONTENT_SEL=1, bit i is INIT_BITS[i].
- R3: dout_oe is low whenever en_n is high, the reset input is active, or the device has finished. dout reads 0 whenever dout_oe is low.
- R4: With RST_ACTIVE_HIGH=1 the reset input is active at level 1. With RST_ACTIVE_HIGH=0 it is active at level 0.
- R5: A rising edge with reset active sets the address to zero and clears the finished state, so the stream restarts at bit 0.
- R6: The edge that ends the last bit (address DEPTH-1) puts the device in the finished state. In that state dout_oe is low and casc_n is low. The address does not wrap, and the state lasts until reset.
- R7: casc_n is high (inactive) while reset is active or en_n is high.
- R8: While en_n is high, clock edges leave the address and the finished state unchanged, so the stream resumes where it stopped.
- R9: When two devices are chained with the first casc_n driving the second en_n, at most one of them drives at a time. The shared line carries the first device's bits followed directly by the second device's bits, and it floats once both have finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, shared along the chain |
| en_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined pointer reset and output gate; active level set by RST_ACTIVE_HIGH |
| dout | output | 1 | Serial data bit (0 while not driving) |
| dout_oe | output | 1 | High while this device drives the shared line |
| casc_n | output | 1 | Cascade enable for the next device, active low |

## Verification
The hardest situation to reach from the ports is the handoff between the devices when it is disturbed. One disturbance is a pause or a reset that arrives while the second device is mid-stream. The other is the first clock edges after the first device finishes, where a single-cycle overlap or gap would show up. The stimulus is a long chained run with random enable pauses and rare random reset pulses. A directed sequence then forces a reset just after the handoff and runs both devices to completion. After that, a separate active-low instance with parameter contents checks the polarity option, the stop at terminal count and the restart after reset.

// File: rtl/serial_cfg_rom_pkg.sv
package serial_cfg_rom_pkg;

    localparam logic [31:0] GEN_MULT = 32'd40503;

    // Deterministic content generator: parity of a scrambled index.
    function automatic logic gen_bit(input logic [31:0] idx, input logic [15:0] seed);
        logic [31:0] prod;
        prod = idx * GEN_MULT;
        return ^(prod[15:0] ^ seed);
    endfunction

endpackage

// File: rtl/serial_rom_addr_ctr.sv
module serial_rom_addr_ctr #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_act,
    input  logic          en_act,
    output logic [AW-1:0] addr_o,
    output logic          done_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          done;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (rst_act) begin
            ctr_d.addr = '0;
            ctr_d.done = 1'b0;
        end else if (en_act && !ctr_q.done) begin
            if (ctr_q.addr == LAST) begin
                ctr_d.done = 1'b1;
            end else begin
                ctr_d.addr = ctr_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        ctr_q <= ctr_d;
    end

    assign addr_o = ctr_q.addr;
    assign done_o = ctr_q.done;
endmodule

// File: rtl/serial_rom_store.sv
module serial_rom_store #(
    parameter int unsigned      DEPTH       = 256,
    parameter int unsigned      CONTENT_SEL = 0,
    parameter logic [15:0]      SEED        = 16'h5A3C,
    parameter logic [DEPTH-1:0] INIT_BITS   = '0,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] addr_i,
    output logic          bit_o
);
    import serial_cfg_rom_pkg::*;

    generate
        if (CONTENT_SEL == 0) begin : g_gen
            always_comb bit_o = gen_bit(32'(addr_i), SEED);
        end else begin : g_vec
            always_comb bit_o = INIT_BITS[addr_i];
        end
    endgenerate
endmodule

// File: rtl/serial_rom_drive.sv
module serial_rom_drive (
    input  logic rst_act,
    input  logic en_act,
    input  logic done_i,
    input  logic bit_i,
    output logic dout,
    output logic dout_oe,
    output logic casc_n
);
    logic live;

    always_comb begin
        live    = en_act && !rst_act;
        dout_oe = live && !done_i;
        dout    = dout_oe && bit_i;
        casc_n  = !(live && done_i);
    end
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
    parameter int unsigned      DEPTH           = 256,
    parameter bit               RST_ACTIVE_HIGH = 1'b1,
    parameter int unsigned      CONTENT_SEL     = 0,
    parameter logic [15:0]      SEED            = 16'h5A3C,
    parameter logic [DEPTH-1:0] INIT_BITS       = '0
) (
    input  logic clk,
    input  logic en_n,
    input  logic rst_oe,
    output logic dout,
    output logic dout_oe,
    output logic casc_n
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          rst_act;
    logic          en_act;
    logic [AW-1:0] addr_q;
    logic          done_q;
    logic          bit_w;

    generate
        if (RST_ACTIVE_HIGH) begin : g_rst_hi
            assign rst_act = rst_oe;
        end else begin : g_rst_lo
            assign rst_act = !rst_oe;
        end
    endgenerate

    assign en_act = !en_n;

    serial_rom_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk     (clk),
        .rst_act (rst_act),
        .en_act  (en_act),
        .addr_o  (addr_q),
        .done_o  (done_q)
    );

    serial_rom_store #(
        .DEPTH       (DEPTH),
        .CONTENT_SEL (CONTENT_SEL),
        .SEED        (SEED),
        .INIT_BITS   (INIT_BITS)
    ) u_store (
        .addr_i (addr_q),
        .bit_o  (bit_w)
    );

    serial_rom_drive u_drv (
        .rst_act (rst_act),
        .en_act  (en_act),
        .done_i  (done_q),
        .bit_i   (bit_w),
        .dout    (dout),
        .dout_oe (dout_oe),
        .casc_n  (casc_n)
    );
endmodule

// File: rtl/serial_cfg_rom_chk.sv
module serial_cfg_rom_chk #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_act,
    input logic          en_act,
    input logic [AW-1:0] addr_q,
    input logic          done_q,
    input logic          dout_oe,
    input logic          casc_n
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic seen_q = 1'b0;
    always_ff @(posedge clk) seen_q <= seen_q | rst_act;

    assert_oe_gate_R3: assert property (@(posedge clk) disable iff (!seen_q)
        dout_oe |-> (en_act && !rst_act && !done_q));

    assert_casc_gate_R7: assert property (@(posedge clk) disable iff (!seen_q)
        !casc_n |-> (en_act && !rst_act));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!seen_q)
        !casc_n |-> !dout_oe);

    assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!seen_q)
        rst_act |=> (addr_q == '0 && !done_q));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!seen_q || rst_act)
        !en_act |=> ($stable(addr_q) && $stable(done_q)));

    assert_step_R1: assert property (@(posedge clk) disable iff (!seen_q || rst_act)
        (en_act && !done_q && addr_q != LAST) |=> (addr_q == $past(addr_q) + 1'b1));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!seen_q || rst_act)
        done_q |=> (done_q && addr_q == LAST));
endmodule

bind serial_cfg_rom serial_cfg_rom_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_act (rst_act),
    .en_act  (en_act),
    .addr_q  (addr_q),
    .done_q  (done_q),
    .dout_oe (dout_oe),
    .casc_n  (casc_n)
);

// File: tb/sim_serial_cfg_rom.sv
module sim_serial_cfg_rom;
    localparam int D = 256;
    localparam logic [15:0] S0 = 16'h5A3C;
    localparam logic [15:0] S1 = 16'h1F07;
    localparam logic [7:0]  V2 = 8'b1011_0010;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done_run = 1'b0;

    // chain: u0 -> u1, active-high reset
    logic en0_n = 1'b1, rst = 1'b1;
    logic d0, oe0, c0_n, d1, oe1, c1_n;
    // standalone active-low instance
    logic en2_n = 1'b1, rst2_n = 1'b0;
    logic d2, oe2, c2_n;

    serial_cfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1), .SEED(S0)) u0 (
        .clk(clk), .en_n(en0_n), .rst_oe(rst), .dout(d0), .dout_oe(oe0), .casc_n(c0_n));
    serial_cfg_rom #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1), .SEED(S1)) u1 (
        .clk(clk), .en_n(c0_n), .rst_oe(rst), .dout(d1), .dout_oe(oe1), .casc_n(c1_n));
    serial_cfg_rom #(.DEPTH(8), .RST_ACTIVE_HIGH(1'b0), .CONTENT_SEL(1), .INIT_BITS(V2)) u2 (
        .clk(clk), .en_n(en2_n), .rst_oe(rst2_n), .dout(d2), .dout_oe(oe2), .casc_n(c2_n));

    function automatic logic ref_bit(input int i, input logic [15:0] s);
        logic [31:0] m;
        m = 32'(i) * 32'd40503;
        return ^(m[15:0] ^ s);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
        end
    endtask

    int p = 0;  // bits consumed from the chain

    task automatic step(input logic en_v, input logic rst_v);
        logic live;
        @(negedge clk);
        en0_n = en_v;
        rst   = rst_v;
        #1;
        live = !rst_v && !en_v;
        chk(oe0,  live && p < D,            "R3 u0 oe");
        chk(oe1,  live && p >= D && p < 2*D, "R9 u1 oe");
        chk(c0_n, !(live && p >= D),        "R6 u0 casc");
        chk(c1_n, !(live && p >= 2*D),      "R7 u1 casc");
        chk(oe0 && oe1, 1'b0,               "R9 no overlap");
        if (live && p < D) chk(d0, ref_bit(p, S0), "R1 R2 u0 data");
        if (live && p >= D && p < 2*D) chk(d1, ref_bit(p - D, S1), "R9 u1 data");
        if (!oe0) chk(d0, 1'b0, "R3 u0 quiet");
        if (!oe1) chk(d1, 1'b0, "R3 u1 quiet");
        if (rst_v) p = 0;
        else if (!en_v && p < 2*D) p++;
    endtask

    task automatic step2(input logic en_v, input logic rstn_v,
                         input logic e_oe, input logic e_d, input logic e_c, input string tag);
        @(negedge clk);
        en2_n  = en_v;
        rst2_n = rstn_v;
        #1;
        chk(oe2, e_oe, tag);
        if (e_oe) chk(d2, e_d, tag);
        chk(c2_n, e_c, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done_run) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd1234);
        // reset state R5, R7
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        // random run through both devices: pauses (R8) and rare resets (R5)
        for (int k = 0; k < 1500; k++) begin
            logic pause, rr;
            pause = ($urandom % 4) == 0;
            rr    = ($urandom % 300) == 0;
            step(pause, rr);
        end
        // directed: reset just after the handoff R5, R9
        step(1'b0, 1'b1);
        while (p < D + 3) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        // full clean chain to completion, then float R6, R9
        while (p < 2*D) step(1'b0, 1'b0);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);  // disable after completion: cascade off R7
        step(1'b0, 1'b0);

        // active-low polarity instance R4, R2 (vector contents), R6 no wrap
        step2(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 low reset floats");
        step2(1'b0, 1'b1, 1'b1, V2[0], 1'b1, "R4 release bit0");
        for (int k = 1; k < 8; k++) step2(1'b0, 1'b1, 1'b1, V2[k], 1'b1, "R2 vector bit");
        for (int k = 0; k < 4; k++) step2(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 stays finished");
        step2(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7 en off casc off");
        step2(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 still finished");
        step2(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 reset");
        step2(1'b0, 1'b1, 1'b1, V2[0], 1'b1, "R5 restart bit0");
        step2(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8 pause");
        step2(1'b0, 1'b1, 1'b1, V2[1], 1'b1, "R8 resume bit1");

        done_run = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule